// File: doc/BRIEF.md
# Prescaled PWM Down-Counter Generator

This block generates one pulse-width-modulated output from a 16-bit down-counter. The counter advances on a slow tick. The tick comes from a programmable prescaler followed by a power-of-two divider. Software programs a period, a compare value, the clock configuration and a control word through a plain write port: one strobe, a two-bit address and a data word. There is no read path. The live counter value and a period interrupt flag are brought out as ports.

Each output cycle starts with a reload. On the tick that finds the counter at zero, the counter loads the current period value and samples the compare value. The pin is high while the counter sits at or below the sampled compare value. Software stops the block gracefully in two steps. It first writes a zero period, which lets the counter run down to zero and stay there. It then clears the run bit. The pin has its own enable, separate from the run bit.

Top module: `pwm_gen`

## Requirements
- R1: After reset, count_o is 0, pwm_o is 0 and irq_o is 0.
- R2: While running, each tick lowers a nonzero count by one. A tick at count 0 reloads the count with the period register. One output cycle therefore lasts period+1 ticks.
- R3: The pin is high while the count is at or below the compare value sampled at the last reload. This gives compare+1 high ticks per cycle. A compare value at or above the period keeps the pin high for the whole cycle.
- R4: The clock configuration register (address 3) sets the tick rate. Bits 7:0 hold a prescale value PS, which divides the clock by PS+1. Bits 10:8 hold a divider select S, which divides further by 2^S. Any S above 4 acts as 4.
- R5: A period or compare write never alters the cycle in progress. The counter keeps stepping down, and the new values apply from the next reload.
- R6: Every reload sets irq_o one cycle later. Writing address 0 with bit 2 set clears irq_o. If a reload and a clear fall in the same cycle, the set wins.
- R7: When the period register holds 0, the counter finishes its run down to 0 and then stays at 0.
- R8: When the output-enable bit (address 0, bit 1) is 0, pwm_o stays 0. The counter keeps running exactly as it would with the pin enabled.
- R9: One cycle after the run bit (address 0, bit 0) is cleared, count_o is 0. pwm_o is 0 while the run bit is clear. Setting the run bit again restarts the prescaler and divider from zero.
- R10: Register map: address 0 is control (bit 0 run, bit 1 output enable, bit 2 write-one-to-clear the interrupt). Address 1 is the period, address 2 the compare value, address 3 the clock configuration. A write takes effect at the clock edge on which wr_en_i is high.
- R11: With PS=0, S=0 and a nonzero period, count_o equals the period one cycle after the run bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | Gated PWM output |
| count_o | output | 16 | Live counter value |
| irq_o | output | 1 | Period interrupt flag |

## Verification
The waveform is exercised with several settings: a short period with a small compare value, a compare value above the period, and a reprogramming of the period in mid-cycle. These runs separate a correct high-time and cycle length from off-by-one errors, and show whether a new value is applied at once or at the reload. The clock configuration is run with an odd prescale combined with a divider, and again with an out-of-range divider select. Measuring the gap between count changes tells the two stages apart and exposes a missing clamp. The stop sequence, the pin gating with the counter still running, and the interrupt clear are each observed at the ports. A behavioural model is compared on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_PERIOD  = 2'd1,
    ADDR_COMPARE = 2'd2,
    ADDR_CLKCFG  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_RUN_BIT     = 0;
  localparam int unsigned CTRL_OE_BIT      = 1;
  localparam int unsigned CTRL_IRQ_CLR_BIT = 2;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PS_W   = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              run_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] compare_o,
  output logic [PS_W-1:0]   prescale_o,
  output logic [SEL_W-1:0]  div_sel_o,
  output logic              irq_clr_o
);
  localparam int unsigned CFG_W = PS_W + SEL_W;

  logic is_ctrl;
  assign is_ctrl   = wr_en_i && (reg_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign irq_clr_o = is_ctrl && wr_data_i[CTRL_IRQ_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o      <= 1'b0;
      oe_o       <= 1'b0;
      period_o   <= '0;
      compare_o  <= '0;
      prescale_o <= '0;
      div_sel_o  <= '0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        ADDR_CTRL: begin
          run_o <= wr_data_i[CTRL_RUN_BIT];
          oe_o  <= wr_data_i[CTRL_OE_BIT];
        end
        ADDR_PERIOD:  period_o  <= wr_data_i;
        ADDR_COMPARE: compare_o <= wr_data_i;
        ADDR_CLKCFG: begin
          prescale_o <= wr_data_i[PS_W-1:0];
          div_sel_o  <= wr_data_i[CFG_W-1:PS_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned PS_W         = 8,
  parameter int unsigned SEL_W        = 3,
  parameter int unsigned DIV_LOG2_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PS_W-1:0]  prescale_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  logic [PS_W-1:0] pre_q;
  logic            pre_wrap;

  assign pre_wrap = pre_q >= prescale_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || pre_wrap) pre_q <= '0;
    else                        pre_q <= pre_q + PS_W'(1);
  end

  generate
    if (DIV_LOG2_MAX == 0) begin : g_no_div
      assign tick_o = run_i && pre_wrap;
    end else begin : g_div
      localparam int unsigned DIV_W = DIV_LOG2_MAX;
      localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DIV_LOG2_MAX);

      logic [SEL_W-1:0] sel_c;
      logic [DIV_W-1:0] div_last;
      logic [DIV_W-1:0] div_q;
      logic             div_wrap;

      // out-of-range selects saturate at the largest divider
      assign sel_c    = (div_sel_i > SEL_MAX) ? SEL_MAX : div_sel_i;
      assign div_last = DIV_W'((32'd1 << sel_c) - 32'd1);
      assign div_wrap = div_q >= div_last;
      assign tick_o   = run_i && pre_wrap && div_wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       div_q <= '0;
        else if (!run_i)   div_q <= '0;
        else if (pre_wrap) div_q <= div_wrap ? '0 : div_q + DIV_W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             valid_o,
  output logic             irq_o
);
  logic reload;
  assign reload = run_i && tick_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      cmp_act_o <= '0;
      valid_o   <= 1'b0;
    end else if (!run_i) begin
      cnt_o   <= '0;
      valid_o <= 1'b0;
    end else if (reload) begin
      cnt_o     <= period_i;
      cmp_act_o <= compare_i;
      valid_o   <= 1'b1;
    end else if (tick_i) begin
      cnt_o <= cnt_o - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_o <= 1'b0;
    else if (reload)    irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             run_i,
  input  logic             oe_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_act_i,
  output logic             pwm_o
);
  logic raw;
  assign raw   = valid_i && (cnt_i <= cmp_act_i);
  assign pwm_o = run_i && oe_i && raw;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned PS_W         = 8,
  parameter int unsigned SEL_W        = 3,
  parameter int unsigned DIV_LOG2_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic             run_q, oe_q, irq_clr, tick, valid;
  logic [CNT_W-1:0] period_q, compare_q, cmp_act;
  logic [PS_W-1:0]  prescale_q;
  logic [SEL_W-1:0] div_sel_q;

  pwm_regs #(.DATA_W(CNT_W), .PS_W(PS_W), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .run_o      (run_q),
    .oe_o       (oe_q),
    .period_o   (period_q),
    .compare_o  (compare_q),
    .prescale_o (prescale_q),
    .div_sel_o  (div_sel_q),
    .irq_clr_o  (irq_clr)
  );

  pwm_tick_gen #(.PS_W(PS_W), .SEL_W(SEL_W), .DIV_LOG2_MAX(DIV_LOG2_MAX)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .prescale_i (prescale_q),
    .div_sel_i  (div_sel_q),
    .tick_o     (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .tick_i    (tick),
    .period_i  (period_q),
    .compare_i (compare_q),
    .irq_clr_i (irq_clr),
    .cnt_o     (count_o),
    .cmp_act_o (cmp_act),
    .valid_o   (valid),
    .irq_o     (irq_o)
  );

  pwm_out #(.CNT_W(CNT_W)) u_out (
    .run_i     (run_q),
    .oe_i      (oe_q),
    .valid_i   (valid),
    .cnt_i     (count_o),
    .cmp_act_i (cmp_act),
    .pwm_o     (pwm_o)
  );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic             oe_q,
  input logic             tick,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] compare_q,
  input logic [CNT_W-1:0] cmp_act,
  input logic             irq_o,
  input logic             pwm_o
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick && count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick) |=> $stable(count_o));

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick && count_o == '0) |=> (count_o == $past(period_q)));

  assert_cmp_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick && count_o == '0) |=> (cmp_act == $past(compare_q)));

  assert_irq_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick && count_o == '0) |=> irq_o);

  assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> !pwm_o);

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> (count_o == '0));
endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_q     (run_q),
  .oe_q      (oe_q),
  .tick      (tick),
  .count_o   (count_o),
  .period_q  (period_q),
  .compare_q (compare_q),
  .cmp_act   (cmp_act),
  .irq_o     (irq_o),
  .pwm_o     (pwm_o)
);

// File: tb/pwm_gen_tb_top.sv
module pwm_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        pwm_o;
  logic [15:0] count_o;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pwm_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .pwm_o(pwm_o), .count_o(count_o), .irq_o(irq_o)
  );

  // behavioural reference
  bit m_run, m_oe, m_irq, m_live;
  int m_per, m_cmp, m_ps, m_sel, m_pre, m_div, m_cnt, m_acmp;

  function automatic int divisor(int sel);
    return 1 << ((sel > 4) ? 4 : sel);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_oe = 0; m_irq = 0; m_live = 0;
      m_per = 0; m_cmp = 0; m_ps = 0; m_sel = 0;
      m_pre = 0; m_div = 0; m_cnt = 0; m_acmp = 0;
    end else begin
      bit pw, tk, rl, clr;
      pw  = m_pre >= m_ps;
      tk  = m_run && pw && (m_div >= divisor(m_sel) - 1);
      rl  = tk && m_cnt == 0;
      clr = wr_en_i && wr_addr_i == 2'd0 && wr_data_i[2];
      if (!m_run) begin
        m_pre = 0; m_div = 0; m_cnt = 0; m_live = 0;
      end else begin
        if (pw) begin
          m_pre = 0;
          m_div = (m_div >= divisor(m_sel) - 1) ? 0 : m_div + 1;
        end else m_pre++;
        if (rl) begin
          m_cnt = m_per; m_acmp = m_cmp; m_live = 1;
        end else if (tk) m_cnt--;
      end
      if (rl) m_irq = 1;
      else if (clr) m_irq = 0;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin m_run = wr_data_i[0]; m_oe = wr_data_i[1]; end
          2'd1: m_per = wr_data_i;
          2'd2: m_cmp = wr_data_i;
          default: begin m_ps = wr_data_i[7:0]; m_sel = wr_data_i[10:8]; end
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit mp;
      mp = m_run && m_oe && m_live && (m_cnt <= m_acmp);
      chk(count_o == 16'(m_cnt), "R2 model count", count_o, m_cnt);
      chk(pwm_o == mp, "R3 model pwm", pwm_o, mp);
      chk(irq_o == m_irq, "R6 model irq", irq_o, m_irq);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic gap(output int n);
    int prev;
    prev = count_o; n = 0;
    do begin step(); n++; end while (count_o == prev && n < 200);
  endtask

  initial begin
    int n, hi;
    bit moved;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(pwm_o == 0, "R1 pwm", pwm_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);

    // R10 register map: period, compare, clkcfg, ctrl
    wr(2'd1, 16'd5); wr(2'd2, 16'd1); wr(2'd3, 16'd0); wr(2'd0, 16'd3);
    step();
    chk(count_o == 5, "R11 first reload", count_o, 5);
    chk(irq_o == 1, "R6 set on reload", irq_o, 1);
    hi = 0;
    for (int i = 0; i < 6; i++) begin step(); if (pwm_o) hi++; end
    chk(hi == 2, "R3 high ticks", hi, 2);
    chk(count_o == 5, "R2 cycle length", count_o, 5);

    wr(2'd0, 16'd7);
    chk(irq_o == 0, "R6 clear", irq_o, 0);
    wr(2'd1, 16'd2);
    chk(count_o == 3, "R5 no jump", count_o, 3);
    while (count_o != 0) step();
    step();
    chk(count_o == 2, "R5 new period at reload", count_o, 2);

    wr(2'd0, 16'd0);
    step();
    chk(count_o == 0, "R9 stopped count", count_o, 0);
    chk(pwm_o == 0, "R9 stopped pwm", pwm_o, 0);

    wr(2'd1, 16'd3); wr(2'd3, 16'h0102); wr(2'd0, 16'd3);
    gap(n); gap(n);
    chk(n == 6, "R4 prescale and divider", n, 6);
    wr(2'd3, 16'h0700);
    gap(n); gap(n); gap(n);
    chk(n == 16, "R4 select clamp", n, 16);

    wr(2'd3, 16'd0); wr(2'd0, 16'd1);
    hi = 0; moved = 0; n = count_o;
    for (int i = 0; i < 10; i++) begin
      step(); if (pwm_o) hi++; if (count_o != n) moved = 1;
    end
    chk(hi == 0, "R8 pin gated", hi, 0);
    chk(moved == 1, "R8 counter runs", moved, 1);

    wr(2'd2, 16'd7); wr(2'd0, 16'd3);
    repeat (6) step();
    hi = 0;
    for (int i = 0; i < 6; i++) begin step(); if (pwm_o) hi++; end
    chk(hi == 6, "R3 compare above period", hi, 6);

    wr(2'd1, 16'd0);
    repeat (10) step();
    n = 0;
    for (int i = 0; i < 10; i++) begin step(); if (count_o != 0) n++; end
    chk(n == 0, "R7 drained to zero", n, 0);

    wr(2'd0, 16'd0);
    step();
    chk(count_o == 0 && pwm_o == 0, "R9 force stop", count_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule